// File: doc/BRIEF.md
# Reference Divider with Test Output Select

This block turns a reference clock enable into a slower comparison pulse for a frequency synthesizer loop. It counts enabled reference cycles and issues a single-cycle pulse at one of three ratios. Two select bits pick the ratio: 640, 1024 or 512. When the selected ratio changes, the count starts again from zero, so no period comes out with a length that belongs to neither ratio.

A three-bit test code sets what drives the charge-pump controls and the lock pin. In normal operation, the lock pin carries the phase detector's lock flag, and the pump controls follow the detector's up and down requests. Other codes can switch the pump off or force it to sink or source current. Two codes put internal clocks on the lock pin instead: the divided reference pulse, or a square wave at half the divided VCO rate. Every output is registered.

Top module: `refdiv_testmux`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs (`ref_pulse`, `lock_out`, `pump_src`, `pump_snk`, `pump_off`) are 0 after that edge.
- R2: With `ratio_b` = 0, a pulse follows every 640 enabled reference cycles, whatever the value of `ratio_a`.
- R3: With `ratio_b` = 1 and `ratio_a` = 0, a pulse follows every 1024 enabled reference cycles.
- R4: With `ratio_b` = 1 and `ratio_a` = 1, a pulse follows every 512 enabled reference cycles.
- R5: `ref_pulse` is high for one cycle per period. Only cycles with `ref_en` high advance the count, and the pulse comes in the cycle after the edge that samples the final enabled cycle.
- R6: When the selected ratio value differs from the value in the previous cycle, the count restarts at zero and no pulse is issued on that edge. Switching between two encodings that both give 640 does not restart the count.
- R7: For `test_code` (bit 2 = T2, bit 0 = T0) equal to 000 or 001, on the next edge `lock_out` takes `pd_lock`, `pump_src` takes `pd_up`, `pump_snk` takes `pd_down`, and `pump_off` takes 0.
- R8: For `test_code` 010 or 011, on the next edge `pump_off` becomes 1 and both `pump_src` and `pump_snk` become 0. `lock_out` takes `pd_lock`.
- R9: For `test_code` 110, on the next edge only `pump_snk` is 1. For 111, only `pump_src` is 1. In both cases `lock_out` takes `pd_lock`.
- R10: For `test_code` 100, `lock_out` takes the value `ref_pulse` had in the previous cycle, and the pump controls behave as in R7.
- R11: A state bit that starts at 0 after reset toggles on every cycle with `vco_pulse` high. For `test_code` 101, `lock_out` takes that bit's value from before the edge, and the pump controls behave as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference cycle enable |
| vco_pulse | input | 1 | Divided VCO pulse |
| ratio_a | input | 1 | Ratio select bit A |
| ratio_b | input | 1 | Ratio select bit B |
| test_code | input | 3 | Test code, bit 2 = T2, bit 0 = T0 |
| pd_lock | input | 1 | Lock flag from the phase detector |
| pd_up | input | 1 | Pump-up request from the phase detector |
| pd_down | input | 1 | Pump-down request from the phase detector |
| ref_pulse | output | 1 | Divided reference pulse |
| lock_out | output | 1 | Lock pin value |
| pump_src | output | 1 | Charge pump source control |
| pump_snk | output | 1 | Charge pump sink control |
| pump_off | output | 1 | Charge pump off control |

## Verification
The bench switches the ratio in the middle of a period. A design that kept its count would produce a short first period, and the model catches that. It also moves between the two encodings that both give 640; a design that restarted on a change of code rather than a change of ratio would drift one period late. With `ref_en` gated at random, a counter that ran on every clock would pulse early. The bench walks through all eight test codes with random detector inputs, which would expose a swapped sink/source decode, a pump that did not switch off for both 01x codes, or the wrong clock on the lock pin.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  typedef enum logic [2:0] {
    MODE_NORM,
    MODE_OFF,
    MODE_SINK,
    MODE_SRC,
    MODE_REFOUT,
    MODE_HALFOUT
  } out_mode_t;

  function automatic out_mode_t decode_test(input logic [2:0] code);
    case (code)
      3'b010, 3'b011: decode_test = MODE_OFF;
      3'b110:         decode_test = MODE_SINK;
      3'b111:         decode_test = MODE_SRC;
      3'b100:         decode_test = MODE_REFOUT;
      3'b101:         decode_test = MODE_HALFOUT;
      default:        decode_test = MODE_NORM;
    endcase
  endfunction

endpackage

// File: rtl/refdiv_ratio_cnt.sv
module refdiv_ratio_cnt #(
  parameter int RATIO_LOW  = 640,
  parameter int RATIO_MID  = 1024,
  parameter int RATIO_HIGH = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sel_a,
  input  logic sel_b,
  output logic pulse
);
  localparam int MAXR = (RATIO_LOW > RATIO_MID) ?
                        ((RATIO_LOW > RATIO_HIGH) ? RATIO_LOW : RATIO_HIGH) :
                        ((RATIO_MID > RATIO_HIGH) ? RATIO_MID : RATIO_HIGH);
  localparam int RW = $clog2(MAXR + 1);

  logic [RW-1:0] ratio_now, ratio_q, term;
  logic [RW-1:0] cnt;

  always_comb begin
    if (!sel_b)     ratio_now = RW'(RATIO_LOW);
    else if (sel_a) ratio_now = RW'(RATIO_HIGH);
    else            ratio_now = RW'(RATIO_MID);
    term = ratio_now - RW'(1);
  end

  always_ff @(posedge clk) begin
    ratio_q <= ratio_now;
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (ratio_now != ratio_q) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (en) begin
      if (cnt == term) begin
        cnt   <= '0;
        pulse <= 1'b1;
      end else begin
        cnt   <= cnt + RW'(1);
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/refdiv_toggle.sv
module refdiv_toggle (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic half
);
  always_ff @(posedge clk) begin
    if (rst)       half <= 1'b0;
    else if (tick) half <= ~half;
  end
endmodule

// File: rtl/refdiv_outmux.sv
module refdiv_outmux
  import refdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] code,
  input  logic       pd_lock,
  input  logic       pd_up,
  input  logic       pd_down,
  input  logic       ref_int,
  input  logic       half_int,
  output logic       lock_out,
  output logic       pump_src,
  output logic       pump_snk,
  output logic       pump_off
);
  out_mode_t mode;
  logic lock_d, src_d, snk_d, off_d;

  always_comb begin
    mode   = decode_test(code);
    lock_d = pd_lock;
    src_d  = pd_up;
    snk_d  = pd_down;
    off_d  = 1'b0;
    case (mode)
      MODE_OFF:     begin src_d = 1'b0; snk_d = 1'b0; off_d = 1'b1; end
      MODE_SINK:    begin src_d = 1'b0; snk_d = 1'b1; end
      MODE_SRC:     begin src_d = 1'b1; snk_d = 1'b0; end
      MODE_REFOUT:  lock_d = ref_int;
      MODE_HALFOUT: lock_d = half_int;
      default:      ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_out <= 1'b0;
      pump_src <= 1'b0;
      pump_snk <= 1'b0;
      pump_off <= 1'b0;
    end else begin
      lock_out <= lock_d;
      pump_src <= src_d;
      pump_snk <= snk_d;
      pump_off <= off_d;
    end
  end
endmodule

// File: rtl/refdiv_testmux.sv
module refdiv_testmux #(
  parameter int RATIO_LOW  = 640,
  parameter int RATIO_MID  = 1024,
  parameter int RATIO_HIGH = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_en,
  input  logic       vco_pulse,
  input  logic       ratio_a,
  input  logic       ratio_b,
  input  logic [2:0] test_code,
  input  logic       pd_lock,
  input  logic       pd_up,
  input  logic       pd_down,
  output logic       ref_pulse,
  output logic       lock_out,
  output logic       pump_src,
  output logic       pump_snk,
  output logic       pump_off
);
  logic half_q;

  refdiv_ratio_cnt #(
    .RATIO_LOW (RATIO_LOW),
    .RATIO_MID (RATIO_MID),
    .RATIO_HIGH(RATIO_HIGH)
  ) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .en   (ref_en),
    .sel_a(ratio_a),
    .sel_b(ratio_b),
    .pulse(ref_pulse)
  );

  refdiv_toggle u_half (
    .clk (clk),
    .rst (rst),
    .tick(vco_pulse),
    .half(half_q)
  );

  refdiv_outmux u_mux (
    .clk     (clk),
    .rst     (rst),
    .code    (test_code),
    .pd_lock (pd_lock),
    .pd_up   (pd_up),
    .pd_down (pd_down),
    .ref_int (ref_pulse),
    .half_int(half_q),
    .lock_out(lock_out),
    .pump_src(pump_src),
    .pump_snk(pump_snk),
    .pump_off(pump_off)
  );
endmodule

// File: rtl/refdiv_testmux_chk.sv
module refdiv_testmux_chk (
  input logic       clk,
  input logic       rst,
  input logic       ref_en,
  input logic       vco_pulse,
  input logic       ratio_a,
  input logic       ratio_b,
  input logic [2:0] test_code,
  input logic       pd_lock,
  input logic       pd_up,
  input logic       pd_down,
  input logic       ref_pulse,
  input logic       lock_out,
  input logic       pump_src,
  input logic       pump_snk,
  input logic       pump_off
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> !ref_pulse && !lock_out && !pump_src && !pump_snk && !pump_off);

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse);

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    ((ratio_b != $past(ratio_b)) || (ratio_b && (ratio_a != $past(ratio_a))))
    |=> !ref_pulse);

  assert_normal_R7: assert property (@(posedge clk) disable iff (rst)
    (test_code[2:1] == 2'b00) |=>
      (lock_out == $past(pd_lock)) && (pump_src == $past(pd_up)) &&
      (pump_snk == $past(pd_down)) && !pump_off);

  assert_pump_off_R8: assert property (@(posedge clk) disable iff (rst)
    (test_code[2:1] == 2'b01) |=> pump_off && !pump_src && !pump_snk);

  assert_sink_R9: assert property (@(posedge clk) disable iff (rst)
    (test_code == 3'b110) |=> pump_snk && !pump_src && !pump_off);

  assert_source_R9: assert property (@(posedge clk) disable iff (rst)
    (test_code == 3'b111) |=> pump_src && !pump_snk && !pump_off);

  assert_ref_on_lock_R10: assert property (@(posedge clk) disable iff (rst)
    (test_code == 3'b100) |=> (lock_out == $past(ref_pulse)));
endmodule

bind refdiv_testmux refdiv_testmux_chk u_chk (.*);

// File: tb/refdiv_testmux_tb.sv
`timescale 1ns/1ps
module refdiv_testmux_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_en = 1'b0, vco_pulse = 1'b0, ratio_a = 1'b0, ratio_b = 1'b0;
  logic [2:0] test_code = 3'b001;
  logic pd_lock = 1'b0, pd_up = 1'b0, pd_down = 1'b0;
  logic ref_pulse, lock_out, pump_src, pump_snk, pump_off;

  always #2 clk = ~clk;

  refdiv_testmux u_dut (
    .clk(clk), .rst(rst), .ref_en(ref_en), .vco_pulse(vco_pulse),
    .ratio_a(ratio_a), .ratio_b(ratio_b), .test_code(test_code),
    .pd_lock(pd_lock), .pd_up(pd_up), .pd_down(pd_down),
    .ref_pulse(ref_pulse), .lock_out(lock_out), .pump_src(pump_src),
    .pump_snk(pump_snk), .pump_off(pump_off)
  );

  int checks = 0, fails = 0;
  string tag = "R1";
  bit rand_en = 0, rand_pd = 0, done = 0;

  // behavioural reference model
  int m_cnt = 0, m_last = 640;
  bit m_pulse = 0, m_half = 0, m_lock = 0, m_src = 0, m_snk = 0, m_off = 0;

  function automatic int ratio_of(bit a, bit b);
    if (!b) return 640;
    return a ? 512 : 1024;
  endfunction

  always @(posedge clk) begin
    int r;
    bit np;
    r = ratio_of(ratio_a, ratio_b);
    if (rst) begin
      m_cnt = 0; m_pulse = 0; m_half = 0;
      m_lock = 0; m_src = 0; m_snk = 0; m_off = 0;
    end else begin
      m_lock = pd_lock; m_src = pd_up; m_snk = pd_down; m_off = 0;
      case (test_code)
        3'b010, 3'b011: begin m_src = 0; m_snk = 0; m_off = 1; end
        3'b110: begin m_src = 0; m_snk = 1; end
        3'b111: begin m_src = 1; m_snk = 0; end
        3'b100: m_lock = m_pulse;
        3'b101: m_lock = m_half;
        default: ;
      endcase
      np = 0;
      if (r != m_last) m_cnt = 0;
      else if (ref_en) begin
        if (m_cnt == r - 1) begin m_cnt = 0; np = 1; end
        else m_cnt = m_cnt + 1;
      end
      m_pulse = np;
      if (vco_pulse) m_half = !m_half;
    end
    m_last = r;
  end

  task automatic compare();
    logic [4:0] act, exp;
    act = {ref_pulse, lock_out, pump_src, pump_snk, pump_off};
    exp = {m_pulse, m_lock, m_src, m_snk, m_off};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: {pulse,lock,src,snk,off} actual=%b expected=%b",
               tag, $time, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    if (rand_en) ref_en = ($urandom % 4) != 0;
    if (rand_pd) begin
      pd_lock = 1'($urandom); pd_up = 1'($urandom);
      pd_down = 1'($urandom); vco_pulse = 1'($urandom);
    end
  endtask

  task automatic run(int n, string t);
    tag = t;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    // R1: reset with busy inputs
    pd_lock = 1; pd_up = 1; pd_down = 1; ref_en = 1; vco_pulse = 1;
    run(4, "R1");
    rst = 0;
    pd_lock = 0; pd_up = 0; pd_down = 0; vco_pulse = 0;
    test_code = 3'b001;
    // R2: 640 with both values of ratio_a
    ratio_b = 0; ratio_a = 0;
    run(1300, "R2");
    ratio_a = 1;          // same ratio value: no restart expected (R6)
    run(700, "R6");
    run(700, "R2");
    // R3: 1024
    ratio_b = 1; ratio_a = 0;
    run(2100, "R3");
    // R5: gated enable
    rand_en = 1;
    run(2800, "R5");
    rand_en = 0; ref_en = 1;
    // R4: 512
    ratio_a = 1;
    run(1100, "R4");
    // R6: switch mid-period
    run(300, "R6");
    ratio_a = 0;
    run(1100, "R6");
    ratio_a = 1;
    run(200, "R6");
    // test codes with random detector inputs
    rand_pd = 1;
    test_code = 3'b000; run(200, "R7");
    test_code = 3'b001; run(200, "R7");
    test_code = 3'b010; run(200, "R8");
    test_code = 3'b011; run(200, "R8");
    test_code = 3'b110; run(200, "R9");
    test_code = 3'b111; run(200, "R9");
    test_code = 3'b100; run(1100, "R10");
    test_code = 3'b101; run(400, "R11");
    rand_en = 1;
    test_code = 3'b100; run(1200, "R10");
    test_code = 3'b001; run(100, "R7");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule